// File: doc/BRIEF.md
# Serial Word-Memory Command Front-End

This block is the slave side of a three-wire serial memory port (select, serial clock, data in) with one data-out pin. Behind it sits a small array of 16-bit words, kept here as registers. A host raises select and clocks in a frame. The first 1 seen on a rising serial clock edge is the start bit. Two opcode bits come next, then a word address. For the commands that carry data, one or more 16-bit words follow. Reads stream words back and advance the address pointer on their own. Write-class commands go through a write-enable latch and the W input pin. Each accepted write starts a self-timed programming cycle, and the host can poll its progress on the data-out pin.

All pins are sampled by the system clock through synchronizers. Serial clock edges are found by comparing each synchronized sample with the one before it. A data-out enable stands in for the released (high-impedance) pin. The serial pins carry no valid/ready handshake, so the host applies no back-pressure. The pacing rule is that a write is committed only when select falls in the window that closes at the next serial clock rise after the last data bit. While a programming cycle runs, the engine ignores the serial clock.

Top module: `mw_eeprom_front`

## Requirements
- R1: While the synchronized select is low, `sdo_oe_o` is 0. Dropping select throws away any partial frame.
- R2: With select high and no programming cycle running, 0 bits on data in are skipped. The first 1 sampled on a rising serial clock edge is the start bit.
- R3: Opcode `10` followed by an ADDR_W-bit address, MSB first, is a read. The rising edge that carries the last address bit drives one 0 bit on data out. Each later rising edge drives the next bit of the addressed word, MSB first.
- R4: While select stays high, the read continues with the word at the next address, with no 0 bit between words. The address after the top one is 0.
- R5: Opcode `00` with top address bits `11` sets the write-enable latch. Opcode `00` with top address bits `00` clears it. The latch is clear after reset. No write-class command is carried out while the latch is clear. Reads do not depend on the latch.
- R6: Opcode `01`, an address and 16 data bits write one word. This happens only if the W pin is high when select falls.
- R7: Opcode `11` is a page write of 1 to 4 words. After each word only the two lowest address bits advance, and the upper bits stay fixed.
- R8: Opcode `00` with top address bits `01`, followed by 16 data bits, writes that word to every location.
- R9: A write-class frame is carried out only if select falls after a complete data word and before any further rising serial clock edge. An extra clock edge, or a fall in the middle of a word, cancels the write.
- R10: Once a write has been accepted, data out (when enabled) shows 0 while programming runs. After programming ends it shows 1, until the next start bit is decoded.
- R11: While programming runs, serial clocks and data are ignored, so no frame is decoded.
- R12: A programming cycle lasts exactly PROG_CYCLES system clocks.
- R13: After reset every word of the array reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Select from the host, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in, sampled on rising serial clock |
| wp_n_i | input | 1 | Write permission pin (W); high allows writes |
| sdo_o | output | 1 | Serial data out / ready-busy status |
| sdo_oe_o | output | 1 | Data-out drive enable; 0 means released |

## Verification
The bench builds the block with ADDR_W = 6 (64 words) and PROG_CYCLES = 120. With 64 words, every address can be written and then read back in one sequential stream that crosses the wrap to address 0. With 120 cycles, each write can be followed by a busy-then-ready poll without a long run. The same setting makes the busy window long enough to contain a whole 9-bit read frame, so the test of ignored input sees a real overlap. The two-bit page field makes each page fold-back case short enough to write out by hand and check word by word.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WORD_W = 16;
  localparam int PAGE_N = 4;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_PAGE  = 2'b11;

  localparam logic [1:0] EXT_LOCK  = 2'b00;
  localparam logic [1:0] EXT_FILL  = 2'b01;
  localparam logic [1:0] EXT_ARM   = 2'b11;

  typedef enum logic [2:0] {
    FS_IDLE, FS_OPC, FS_ADDR, FS_DATA, FS_ARMED, FS_READ, FS_SINK
  } frame_st_t;

  typedef enum logic [1:0] {
    WK_NONE, WK_WORD, WK_PAGE, WK_ALL
  } wr_kind_t;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      left <= CW'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/mw_word_mem.sv
module mw_word_mem
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  wr_kind_t                 kind,
  input  logic [ADDR_W-1:0]        base,
  input  logic [2:0]               nwords,
  input  logic [PAGE_N*WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [WORD_W-1:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = $clog2(PAGE_N);

  logic [WORD_W-1:0] cells [DEPTH];
  logic [ADDR_W-1:0] slot_addr [PAGE_N];

  for (genvar j = 0; j < PAGE_N; j++) begin : g_slot
    assign slot_addr[j] = {base[ADDR_W-1:PG_W], base[PG_W-1:0] + PG_W'(j)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) cells[w] <= '1;
    end else if (we) begin
      for (int w = 0; w < DEPTH; w++) begin
        if (kind == WK_ALL) begin
          cells[w] <= wdata[WORD_W-1:0];
        end else begin
          for (int j = 0; j < PAGE_N; j++) begin
            if ((3'(j) < nwords) && (slot_addr[j] == ADDR_W'(w)))
              cells[w] <= wdata[j*WORD_W +: WORD_W];
          end
        end
      end
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_q,
  input  logic                     cs_fall,
  input  logic                     sclk_rise,
  input  logic                     din,
  input  logic                     w_q,
  input  logic                     busy,
  input  logic [WORD_W-1:0]        rdata,
  output logic [ADDR_W-1:0]        raddr,
  output logic                     launch,
  output wr_kind_t                 l_kind,
  output logic [ADDR_W-1:0]        l_addr,
  output logic [2:0]               l_cnt,
  output logic [PAGE_N*WORD_W-1:0] l_data,
  output logic                     start_pulse,
  output logic                     out_bit,
  output logic                     wel
);
  localparam int CNT_W = 5;

  frame_st_t          st;
  logic [1:0]         op;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_sh;
  logic [ADDR_W-1:0]  rd_ptr;
  logic [WORD_W-1:0]  dsh;
  logic [WORD_W-1:0]  rsh;
  logic [2:0]         nwords;
  logic [WORD_W-1:0]  pbuf [PAGE_N];

  logic [ADDR_W-1:0]  a_full;
  logic [1:0]         ext;
  logic [WORD_W-1:0]  word_full;
  logic               launchable;

  assign a_full    = {addr_sh[ADDR_W-2:0], din};
  assign ext       = a_full[ADDR_W-1:ADDR_W-2];
  assign word_full = {dsh[WORD_W-2:0], din};
  assign raddr     = (st == FS_ADDR) ? a_full : rd_ptr;

  assign launchable = (st == FS_ARMED) ||
                      ((st == FS_DATA) && (cnt == '0) && (nwords != '0));

  always_comb begin
    unique case (op)
      OP_WRITE: l_kind = WK_WORD;
      OP_PAGE:  l_kind = WK_PAGE;
      OP_MISC:  l_kind = WK_ALL;
      default:  l_kind = WK_NONE;
    endcase
  end

  assign l_addr = addr_sh;
  assign l_cnt  = nwords;

  for (genvar j = 0; j < PAGE_N; j++) begin : g_flat
    assign l_data[j*WORD_W +: WORD_W] = pbuf[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= FS_IDLE;
      op          <= '0;
      cnt         <= '0;
      addr_sh     <= '0;
      rd_ptr      <= '0;
      dsh         <= '0;
      rsh         <= '0;
      nwords      <= '0;
      launch      <= 1'b0;
      start_pulse <= 1'b0;
      out_bit     <= 1'b0;
      wel         <= 1'b0;
      for (int j = 0; j < PAGE_N; j++) pbuf[j] <= '0;
    end else begin
      launch      <= 1'b0;
      start_pulse <= 1'b0;
      if (!cs_q) begin
        if (cs_fall && launchable && !busy && wel && w_q) launch <= 1'b1;
        st      <= FS_IDLE;
        out_bit <= 1'b0;
      end else if (sclk_rise) begin
        unique case (st)
          FS_IDLE: begin
            if (!busy && din) begin
              st          <= FS_OPC;
              cnt         <= '0;
              start_pulse <= 1'b1;
            end
          end
          FS_OPC: begin
            op  <= {op[0], din};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(1)) begin
              st  <= FS_ADDR;
              cnt <= '0;
            end
          end
          FS_ADDR: begin
            addr_sh <= a_full;
            cnt     <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt    <= '0;
              nwords <= '0;
              unique case (op)
                OP_READ: begin
                  st      <= FS_READ;
                  rsh     <= rdata;
                  rd_ptr  <= a_full + 1'b1;
                  out_bit <= 1'b0;
                end
                OP_WRITE, OP_PAGE: st <= FS_DATA;
                default: begin
                  if (ext == EXT_ARM) begin
                    wel <= 1'b1;
                    st  <= FS_SINK;
                  end else if (ext == EXT_LOCK) begin
                    wel <= 1'b0;
                    st  <= FS_SINK;
                  end else if (ext == EXT_FILL) begin
                    st  <= FS_DATA;
                  end else begin
                    st  <= FS_SINK;
                  end
                end
              endcase
            end
          end
          FS_DATA: begin
            dsh <= word_full;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(WORD_W - 1)) begin
              pbuf[nwords[1:0]] <= word_full;
              nwords <= nwords + 1'b1;
              cnt    <= '0;
              if (!((op == OP_PAGE) && (nwords < 3'(PAGE_N - 1))))
                st <= FS_ARMED;
            end
          end
          FS_ARMED: st <= FS_SINK;
          FS_READ: begin
            out_bit <= rsh[WORD_W-1];
            rsh     <= {rsh[WORD_W-2:0], 1'b0};
            cnt     <= cnt + 1'b1;
            if (cnt == CNT_W'(WORD_W - 1)) begin
              rsh    <= rdata;
              rd_ptr <= rd_ptr + 1'b1;
              cnt    <= '0;
            end
          end
          default: st <= FS_SINK;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic wp_n_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int LANES = 4;

  logic [LANES-1:0] pin_raw;
  logic [LANES-1:0] pin_q;

  assign pin_raw = {wp_n_i, sdi_i, sclk_i, cs_i};

  for (genvar i = 0; i < LANES; i++) begin : g_sync
    mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[i]), .q(pin_q[i])
    );
  end

  logic cs_q, sclk_q, din_q, w_q;
  assign cs_q   = pin_q[0];
  assign sclk_q = pin_q[1];
  assign din_q  = pin_q[2];
  assign w_q    = pin_q[3];

  logic cs_prev, sclk_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_q;
      sclk_prev <= sclk_q;
    end
  end

  logic cs_fall, sclk_rise;
  assign cs_fall   = cs_prev & ~cs_q;
  assign sclk_rise = sclk_q & ~sclk_prev;

  logic                     busy;
  logic                     launch;
  wr_kind_t                 l_kind;
  logic [ADDR_W-1:0]        l_addr;
  logic [2:0]               l_cnt;
  logic [PAGE_N*WORD_W-1:0] l_data;
  logic [ADDR_W-1:0]        raddr;
  logic [WORD_W-1:0]        rdata;
  logic                     start_pulse;
  logic                     out_bit;
  logic                     wel;

  mw_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .din(din_q), .w_q(w_q), .busy(busy),
    .rdata(rdata), .raddr(raddr), .launch(launch), .l_kind(l_kind),
    .l_addr(l_addr), .l_cnt(l_cnt), .l_data(l_data),
    .start_pulse(start_pulse), .out_bit(out_bit), .wel(wel)
  );

  mw_word_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(launch), .kind(l_kind), .base(l_addr),
    .nwords(l_cnt), .wdata(l_data), .raddr(raddr), .rdata(rdata)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy)
  );

  logic stat_mode;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stat_mode <= 1'b0;
    else if (launch)      stat_mode <= 1'b1;
    else if (start_pulse) stat_mode <= 1'b0;
  end

  assign sdo_o    = stat_mode ? ~busy : out_bit;
  assign sdo_oe_o = cs_q;
endmodule

// File: rtl/mw_eeprom_front_chk.sv
module mw_eeprom_front_chk
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 5000
) (
  input logic     clk,
  input logic     rst_n,
  input logic     cs_q,
  input logic     busy,
  input logic     launch,
  input logic     wel,
  input logic     w_q,
  input logic     start_pulse,
  input logic     sdo_o,
  input wr_kind_t l_kind
);
  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  assert_launch_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (wel && w_q));

  assert_launch_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> wel);

  assert_busy_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

  assert_busy_low_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_q) |-> !sdo_o);

  assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_pulse);

  assert_launch_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);

  assert_kind_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (l_kind != WK_NONE));

  assert_prog_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= 32'(PROG_CYCLES));
endmodule

bind mw_eeprom_front mw_eeprom_front_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .busy(busy), .launch(launch),
  .wel(wel), .w_q(w_q), .start_pulse(start_pulse), .sdo_o(sdo_o),
  .l_kind(l_kind)
);

// File: tb/mw_eeprom_front_bench.sv
`timescale 1ns/1ps
module mw_eeprom_front_bench;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int PROG  = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, wpin = 1'b1;
  logic sdo, sdo_oe;

  int total = 0;
  int bad = 0;
  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  mw_eeprom_front #(.ADDR_W(AW), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u_mw_eeprom_front (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
    .wp_n_i(wpin), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic o);
    sdi = b;
    repeat (4) @(negedge clk);
    o = sdo;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic o;
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i], o);
  endtask

  task automatic sel();
    cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    sclk = 1'b0;
    cs = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic misc_cmd(input logic [1:0] ext);
    sel();
    send(1, 1);
    send(2'b00, 2);
    send({ext, 4'b0000}, AW);
    desel();
  endtask

  task automatic write_frame(input int a, input logic [15:0] d);
    sel();
    send(1, 1);
    send(2'b01, 2);
    send(a, AW);
    send(d, 16);
  endtask

  task automatic wait_ready(input string tag);
    cs = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe && !sdo, {tag, " busy"}, {sdo_oe, sdo}, 2'b10);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sdo) break;
    end
    chk(sdo_oe && sdo, {tag, " ready"}, {sdo_oe, sdo}, 2'b11);
    desel();
  endtask

  task automatic read_check(input int a, input int n, input int lead, input string tag);
    logic o;
    logic [15:0] w;
    sel();
    chk(sdo_oe === 1'b1, {tag, " R1 oe"}, sdo_oe, 1);
    send(0, lead);
    send(1, 1);
    send(2'b10, 2);
    send(a, AW);
    clk_bit(1'b0, o);
    chk(o === 1'b0, {tag, " R3 dummy"}, o, 0);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int i = 0; i < 16; i++) begin
        clk_bit(1'b0, o);
        w = {w[14:0], o};
      end
      chk(w === model[(a + k) % DEPTH], tag, w, model[(a + k) % DEPTH]);
    end
    desel();
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'hA5C3 ^ 16'(a * 16'h0111);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R12 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic o;
    int cnt;
    logic allz;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe === 1'b0, "R1 reset oe", sdo_oe, 0);

    // R13 reset contents, R2 leading zeros before start
    read_check(5, 2, 3, "R13 R2 reset");

    // R5: no write while latch clear
    write_frame(3, 16'h1234);
    desel();
    read_check(3, 1, 0, "R5 latch clear");

    // R6: W pin low blocks
    misc_cmd(2'b11);
    wpin = 1'b0;
    write_frame(7, 16'h7777);
    desel();
    wpin = 1'b1;
    read_check(7, 1, 0, "R6 w low");

    // R6 R10 sweep over every address
    for (int a = 0; a < DEPTH; a++) begin
      write_frame(a, pat(a));
      desel();
      model[a] = pat(a);
      wait_ready("R10 sweep");
    end
    // R4 stream with wrap
    read_check(0, DEPTH + 1, 0, "R4 stream");
    read_check(DEPTH - 2, 3, 1, "R4 wrap");

    // R12 duration
    write_frame(10, 16'h0A0A);
    model[10] = 16'h0A0A;
    sclk = 1'b0;
    cs = 1'b0;
    cnt = 0;
    repeat (4) @(negedge clk);
    cnt = 4;
    cs = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cnt++;
      if (sdo_oe && sdo) break;
    end
    chk(cnt >= PROG && cnt <= PROG + 8, "R12 duration", cnt, PROG + 4);
    desel();
    read_check(10, 1, 0, "R12 data");

    // R11: frame during busy ignored
    write_frame(11, 16'hB00B);
    model[11] = 16'hB00B;
    sclk = 1'b0;
    cs = 1'b0;
    repeat (4) @(negedge clk);
    sel();
    allz = 1'b1;
    clk_bit(1'b1, o); allz &= ~o;
    clk_bit(1'b1, o); allz &= ~o;
    clk_bit(1'b0, o); allz &= ~o;
    for (int i = 0; i < AW; i++) begin
      clk_bit(1'b0, o);
      allz &= ~o;
    end
    chk(allz, "R11 busy ignore", allz, 1);
    desel();
    wait_ready("R11");
    read_check(11, 1, 0, "R11 data");

    // R9: extra clock cancels
    write_frame(20, 16'h2020);
    clk_bit(1'b0, o);
    desel();
    read_check(20, 1, 0, "R9 extra edge");
    // R9: early fall cancels
    sel();
    send(1, 1); send(2'b01, 2); send(21, AW); send(16'h1111 >> 1, 15);
    desel();
    read_check(21, 1, 0, "R9 early fall");

    // R7 full page folding low bits
    sel();
    send(1, 1); send(2'b11, 2); send(62, AW);
    send(16'hC001, 16); send(16'hC002, 16); send(16'hC003, 16); send(16'hC004, 16);
    desel();
    model[62] = 16'hC001; model[63] = 16'hC002; model[60] = 16'hC003; model[61] = 16'hC004;
    wait_ready("R7");
    read_check(60, 4, 0, "R7 page4");
    // R7 partial page
    sel();
    send(1, 1); send(2'b11, 2); send(33, AW);
    send(16'hD001, 16); send(16'hD002, 16);
    desel();
    model[33] = 16'hD001; model[34] = 16'hD002;
    wait_ready("R7b");
    read_check(32, 4, 0, "R7 page2");
    // R9 page ended mid word
    sel();
    send(1, 1); send(2'b11, 2); send(40, AW);
    send(16'hE001, 16); send(16'hE002, 16); send(3'b101, 3);
    desel();
    read_check(40, 3, 0, "R9 page abort");

    // R5: disable then write ignored
    misc_cmd(2'b00);
    write_frame(0, 16'h0BAD);
    desel();
    read_check(0, 1, 0, "R5 locked");

    // R8 fill all
    misc_cmd(2'b11);
    sel();
    send(1, 1); send(2'b00, 2); send({2'b01, 4'b0000}, AW); send(16'h3C5A, 16);
    desel();
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h3C5A;
    wait_ready("R8");
    read_check(0, DEPTH, 0, "R8 fill");

    chk(sdo_oe === 1'b0, "R1 final oe", sdo_oe, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule